// File: doc/BRIEF.md
# Square-Array Sequential Rotator

The block rotates an N-bit word cyclically, where N = SIDE*SIDE. The word sits in a SIDE-by-SIDE array of shift cells. Column `col` (0-based, left to right) holds bits `col*SIDE` up to `col*SIDE+SIDE-1`, and the lowest of these bits is in the bottom row. Every cell has exactly two ways in. One is from the cell below it in the same column. The other is from the cell in the same row of the column to its left. The top cell of each column feeds the bottom cell of the next column, and the last column wraps around to the first. All cells move together, one step per clock.

A user first loads a word and then issues a start with an amount `shamt` in the range 0..N-1. The controller splits `shamt` into two parts. The upper log2(SIDE) bits count whole-column steps, and each of these steps rotates the word by SIDE positions. The lower log2(SIDE) bits count single up steps, and each of these rotates the word by one position. All column steps run before any up step. A phase whose count is zero is skipped. The result is the word rotated toward the more significant end by `shamt` places. The controller is a four-state machine:

- **IDLE**: waits for a command. A start moves it to COLS if the upper part is non-zero. Otherwise it goes to UPS if the lower part is non-zero. Otherwise it goes straight to FIN.
- **COLS**: performs one column step per clock. It leaves after the last one, to UPS if up steps remain and to FIN if none remain.
- **UPS**: performs one up step per clock. It moves to FIN after the last one.
- **FIN**: the completion cycle. It always returns to IDLE.

Top module: `sq_rotator`

## Requirements
- R1: During and directly after reset, `busy` and `done` are 0 and `dout` is all zeros.
- R2: A `load` sampled while the block is idle stores `din`. From the next cycle, `dout` shows it, with bit k of `dout` equal to bit k of `din`.
- R3: When `done` is high, `dout[(k+shamt) mod N]` equals bit k of the word that was held when the start was accepted, for every k.
- R4: The column steps come first, and each one rotates `dout` by SIDE places toward the MSB. The up steps follow, and each one rotates `dout` by one place toward the MSB. The intermediate words can be seen on `dout` while the block is busy.
- R5: Let the start be accepted at clock edge 1, and let H = `shamt`/SIDE and L = `shamt` mod SIDE. Then `done` is high in the cycle after edge H+L+1, and `busy` is high from the cycle after edge 1 up to and including that cycle.
- R6: `done` lasts exactly one cycle. It falls together with `busy`, and the block is then idle again.
- R7: A `start` sampled while `busy` is high is ignored. The rotation in progress and its final word are unchanged.
- R8: A `load` sampled while `busy` is high is ignored. `dout` never takes the new `din`.
- R9: A start with `shamt` = 0 raises `done` in the next cycle and leaves `dout` unchanged.
- R10: If `load` and `start` are both sampled in the same idle cycle, the new `din` is stored and that new word is the one rotated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| load | input | 1 | Store `din` into the array when idle |
| din | input | N | Word to be stored |
| start | input | 1 | Begin a rotation when idle |
| shamt | input | 2*log2(SIDE) | Rotation amount, 0..N-1 |
| busy | output | 1 | Rotation in progress, including the completion cycle |
| done | output | 1 | One-cycle completion pulse |
| dout | output | N | Current array contents in bit order |

## Verification
Two things can happen in the same cycle: storing a word and accepting a start. The bench asserts `load` and `start` together while the block is idle. A behavioural model expects the freshly loaded word to be the one rotated. A second kind of overlap is a command arriving while a rotation is in progress. The bench injects a second `start` or a `load` in the middle of a column phase. The per-clock model requires that the intermediate words, the latency and the final word all stay exactly as they would be with no injection.

// File: rtl/sq_rot_pkg.sv
package sq_rot_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_COLS,
        ST_UPS,
        ST_FIN
    } rot_state_t;

    typedef enum logic [1:0] {
        OP_HOLD,
        OP_LOAD,
        OP_UP,
        OP_RIGHT
    } cell_op_t;

endpackage

// File: rtl/sq_cell.sv
module sq_cell
    import sq_rot_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  cell_op_t op,
    input  logic     load_bit,
    input  logic     from_below,
    input  logic     from_left,
    output logic     q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else begin
            unique case (op)
                OP_LOAD:  q <= load_bit;
                OP_UP:    q <= from_below;
                OP_RIGHT: q <= from_left;
                default:  q <= q;
            endcase
        end
    end

endmodule

// File: rtl/sq_ctrl.sv
module sq_ctrl
    import sq_rot_pkg::*;
#(
    parameter int SIDE = 4,
    localparam int LW  = $clog2(SIDE),
    localparam int CW  = 2 * LW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          start,
    input  logic [CW-1:0] shamt,
    output cell_op_t      op,
    output logic          busy,
    output logic          done,
    output rot_state_t    state
);

    rot_state_t    nxt;
    logic [LW-1:0] cnt_cols;
    logic [LW-1:0] cnt_ups;

    wire [LW-1:0] req_cols = shamt[CW-1:LW];
    wire [LW-1:0] req_ups  = shamt[LW-1:0];

    // next-state decision
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    if (req_cols != '0)     nxt = ST_COLS;
                    else if (req_ups != '0) nxt = ST_UPS;
                    else                    nxt = ST_FIN;
                end
            end
            ST_COLS: begin
                if (cnt_cols == LW'(1)) nxt = (cnt_ups != '0) ? ST_UPS : ST_FIN;
            end
            ST_UPS: begin
                if (cnt_ups == LW'(1)) nxt = ST_FIN;
            end
            ST_FIN:  nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    // state register and phase counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cnt_cols <= '0;
            cnt_ups  <= '0;
        end else begin
            state <= nxt;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        cnt_cols <= req_cols;
                        cnt_ups  <= req_ups;
                    end
                end
                ST_COLS: cnt_cols <= cnt_cols - LW'(1);
                ST_UPS:  cnt_ups  <= cnt_ups - LW'(1);
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        op   = OP_HOLD;
        busy = 1'b1;
        done = 1'b0;
        unique case (state)
            ST_IDLE: begin
                busy = 1'b0;
                if (load) op = OP_LOAD;
            end
            ST_COLS: op = OP_RIGHT;
            ST_UPS:  op = OP_UP;
            ST_FIN:  done = 1'b1;
            default: busy = 1'b0;
        endcase
    end

endmodule

// File: rtl/sq_rotator.sv
module sq_rotator
    import sq_rot_pkg::*;
#(
    parameter int SIDE = 4,
    localparam int N   = SIDE * SIDE,
    localparam int CW  = 2 * $clog2(SIDE)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [N-1:0]  din,
    input  logic          start,
    input  logic [CW-1:0] shamt,
    output logic          busy,
    output logic          done,
    output logic [N-1:0]  dout
);

    cell_op_t   cell_op;
    rot_state_t ctl_state;
    logic [N-1:0] grid;

    sq_ctrl #(.SIDE(SIDE)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .start (start),
        .shamt (shamt),
        .op    (cell_op),
        .busy  (busy),
        .done  (done),
        .state (ctl_state)
    );

    for (genvar col = 0; col < SIDE; col++) begin : g_col
        for (genvar row = 0; row < SIDE; row++) begin : g_row
            localparam int IDX   = row + col * SIDE;
            localparam int BELOW = (IDX + N - 1) % N;
            localparam int LEFT  = (IDX + N - SIDE) % N;
            sq_cell u_cell (
                .clk        (clk),
                .rst_n      (rst_n),
                .op         (cell_op),
                .load_bit   (din[IDX]),
                .from_below (grid[BELOW]),
                .from_left  (grid[LEFT]),
                .q          (grid[IDX])
            );
        end
    end

    assign dout = grid;

endmodule

// File: rtl/sq_rot_chk.sv
module sq_rot_chk
    import sq_rot_pkg::*;
#(
    parameter int SIDE = 4,
    localparam int N   = SIDE * SIDE,
    localparam int CW  = 2 * $clog2(SIDE)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          load,
    input logic [N-1:0]  din,
    input logic          start,
    input logic [CW-1:0] shamt,
    input logic          busy,
    input logic          done,
    input logic [N-1:0]  dout,
    input rot_state_t    state
);

    assert_load_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && load) |=> dout == $past(din));

    assert_col_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COLS) |=> dout == {$past(dout[N-SIDE-1:0]), $past(dout[N-1:N-SIDE])});

    assert_up_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_UPS) |=> dout == {$past(dout[N-2:0]), $past(dout[N-1])});

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    assert_busy_persists_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    assert_fin_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FIN) |=> $stable(dout));

    assert_zero_shift_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start && !load && shamt == '0) |=> (done && $stable(dout)));

endmodule

bind sq_rotator sq_rot_chk #(.SIDE(SIDE)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load),
    .din   (din),
    .start (start),
    .shamt (shamt),
    .busy  (busy),
    .done  (done),
    .dout  (dout),
    .state (ctl_state)
);

// File: tb/sq_rotator_tb.sv
`timescale 1ns/1ps
module sq_rotator_tb;

    localparam int SIDE = 4;
    localparam int N    = SIDE * SIDE;
    localparam int CW   = 2 * $clog2(SIDE);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          load = 1'b0;
    logic [N-1:0]  din = '0;
    logic          start = 1'b0;
    logic [CW-1:0] shamt = '0;
    logic          busy, done;
    logic [N-1:0]  dout;

    int errs = 0;
    int checks = 0;

    always #10 clk = ~clk;

    sq_rotator #(.SIDE(SIDE)) u_dut (
        .clk(clk), .rst_n(rst_n), .load(load), .din(din), .start(start),
        .shamt(shamt), .busy(busy), .done(done), .dout(dout)
    );

    function automatic logic [N-1:0] rotl(input logic [N-1:0] v, input int a);
        int s = a % N;
        if (s == 0) return v;
        return (v << s) | (v >> (N - s));
    endfunction

    task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference: 0 idle, 1 rotating, 2 completion cycle
    int mph = 0, m_k = 0, m_h = 0, m_l = 0;
    logic [N-1:0] m_word = '0, m_base = '0;

    function automatic int amt_after(input int k, input int h);
        return (k <= h) ? k * SIDE : h * SIDE + (k - h);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mph = 0; m_word = '0; m_base = '0; m_k = 0;
        end else begin
            case (mph)
                0: begin
                    if (load) m_word = din;
                    if (start) begin
                        m_h = int'(shamt) / SIDE;
                        m_l = int'(shamt) % SIDE;
                        m_k = 0;
                        m_base = m_word;
                        mph = (m_h + m_l == 0) ? 2 : 1;
                    end
                end
                1: begin
                    m_k++;
                    if (m_k == m_h + m_l) mph = 2;
                end
                default: begin
                    m_word = rotl(m_base, m_h * SIDE + m_l);
                    mph = 0;
                end
            endcase
        end
    end

    // per-clock comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R5 busy", N'(busy), N'(mph != 0));
            chk("R6 done", N'(done), N'(mph == 2));
            if (mph == 0) chk("R2 dout idle", dout, m_word);
            else chk("R4 dout step", dout, rotl(m_base, amt_after(m_k, m_h)));
        end
    end

    // mode: 0 plain, 1 load+start together, 2 extra start mid-run, 3 load mid-run
    task automatic run_rot(input logic [N-1:0] data, input int c, input int mode);
        int lat = 0;
        int exp_lat = c / SIDE + c % SIDE + 1;
        @(negedge clk); #2;
        load = 1'b1; din = data;
        if (mode == 1) begin
            start = 1'b1; shamt = CW'(c);
        end else begin
            @(negedge clk); #2;
            load = 1'b0; start = 1'b1; shamt = CW'(c);
        end
        forever begin
            @(negedge clk); #1;
            lat++;
            if (lat == 1) begin load = 1'b0; start = 1'b0; din = ~data; end
            if (lat == 2 && mode == 2) begin start = 1'b1; shamt = CW'(1); end
            if (lat == 2 && mode == 3) begin load = 1'b1; din = 16'hBEEF; end
            if (lat == 3) begin start = 1'b0; load = 1'b0; end
            if (done || lat > 40) break;
        end
        chk($sformatf("R5 latency c=%0d", c), N'(lat), N'(exp_lat));
        case (mode)
            1: chk("R10 load+start final", dout, rotl(data, c));
            2: chk("R7 start ignored final", dout, rotl(data, c));
            3: chk("R8 load ignored final", dout, rotl(data, c));
            default: begin
                if (c == 0) chk("R9 zero shift", dout, data);
                else chk($sformatf("R3 final c=%0d", c), dout, rotl(data, c));
            end
        endcase
        @(negedge clk); #1;
        chk("R6 idle after done", N'({busy, done}), N'(0));
    endtask

    initial begin
        #(20 * 100000);
        errs++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset busy/done", N'({busy, done}), N'(0));
        chk("R1 reset dout", dout, '0);
        #2 rst_n = 1'b1;
        @(negedge clk); #1;
        chk("R1 after reset dout", dout, '0);
        for (int c = 0; c < N; c++) run_rot(N'($urandom), c, 0);
        for (int c = 0; c < N; c++) run_rot(16'h0001, c, 0);
        run_rot(16'h8421, 0, 0);
        run_rot(16'hA5C3, 13, 1);
        run_rot(16'h1234, 0, 1);
        run_rot(16'h0F0F, 13, 2);
        run_rot(16'h7E81, 9, 2);
        run_rot(16'h3C96, 14, 3);
        run_rot(16'hC001, 5, 3);
        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule